// File: doc/BRIEF.md
# Mode Register Timing Guard

This block stands in the command path of a controller for a graphics DDR memory. It watches every command before it reaches the device. When a mode-register-load command passes, the block captures the burst-length and burst-order fields, flags settings the device cannot run, and starts two gap timers. One timer holds back every later non-NOP command other than READ. The other timer, which is longer, holds back READ. The gap values come from a speed-grade parameter.

Commands arrive on a valid/ready stream. The upstream source must hold `in_cmd` and `in_addr` steady while `in_valid` is high and `in_ready` is low. A command is taken in the cycle where both are high. It then appears on the `iss_*` outputs in that same cycle, so a command whose gap has run out passes with no added latency. A NOP is always ready. For each accepted READ or WRITE, the block also produces the four column addresses of the burst over the four following cycles. A further READ or WRITE can be taken on the last beat of a burst, so bursts can run back to back.

Command codes (`in_cmd`): 0 NOP, 1 mode-register load (MRL), 2 activate, 3 READ, 4 WRITE, 5 precharge, 6 refresh, 7 other. Every code other than NOP and READ counts as a "non-read" command.

Top module: `mrs_timing_guard`

## Requirements
- R1: An accepted MRL whose `in_addr[2:0]` equals 3'b010 (burst of four) stores that code on `mode_bl` from the next cycle. `mode_bl` resets to 3'b010.
- R2: An accepted MRL with any other `in_addr[2:0]` code leaves `mode_bl` unchanged and sets `err_bl` from the next cycle. `err_bl` is reloaded by every accepted MRL and resets to 0.
- R3: `in_addr[3]` of an accepted MRL selects burst order. A value of 0 (sequential) is accepted. A value of 1 (interleaved) sets `err_bt` from the next cycle until the next MRL. `err_bt` resets to 0.
- R4: After an MRL accepted in cycle 0 with `in_addr[8]`=0, every non-read command is not ready before cycle tMRD. The gaps are: grade 0 gives tMRD=5 and tMRDR=15; grades 1 and 2 give tMRD=4 and tMRDR=12.
- R5: After an MRL accepted in cycle 0, READ is not ready before cycle tMRDR.
- R6: NOP is always ready and passes straight through.
- R7: An MRL with `in_addr[8]`=1 (DLL reset) pulses `dll_rst_pulse` for the one following cycle and applies no non-read gap. The READ gap still applies.
- R8: In any cycle where `in_ready` and `in_valid` are both high, `iss_valid` is high and `iss_cmd` equals `in_cmd`, with no added latency. In every other cycle, `iss_valid` is low.
- R9: For an issued READ or WRITE, `iss_addr[1:0]` is 0 and the upper bits equal `in_addr`. Other commands pass `in_addr` unchanged.
- R10: A READ or WRITE accepted in cycle 0 drives `col_valid` in cycles 1 to 4. In those cycles `col_addr` is `{in_addr[CW-1:2], k}` for k = 0, 1, 2, 3 in order, `col_last` is high in cycle 4 only, and `col_wr` is high for WRITE.
- R11: READ and WRITE are not ready while a burst is running, except on the burst's last beat.
- R12: `stall` equals `in_valid` and not `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command may be taken this cycle |
| in_cmd | input | 3 | Command code |
| in_addr | input | AW | Address / mode bits |
| stall | output | 1 | Offered command is held back |
| iss_valid | output | 1 | Command issued this cycle |
| iss_cmd | output | 3 | Issued command code |
| iss_addr | output | AW | Issued address, column bits aligned for READ/WRITE |
| mode_bl | output | 3 | Stored burst-length code |
| err_bl | output | 1 | Last MRL had a reserved burst length |
| err_bt | output | 1 | Last MRL asked for interleaved order |
| dll_rst_pulse | output | 1 | One-cycle flag after an MRL with DLL reset |
| col_valid | output | 1 | Column beat valid |
| col_wr | output | 1 | Current burst is a write |
| col_addr | output | CW | Column address of this beat |
| col_last | output | 1 | Final beat of the burst |

## Verification
Two things can hold back a READ or WRITE in the same cycle: a post-MRL gap timer and a running burst. To bring both into play, the bench sends an MRL while a burst is still running and then offers READ and WRITE at once, so the gap expiry falls close to the burst's last beat. In every cycle a bench model, built from the requirements, works out readiness as the conjunction of the two conditions, and the bench compares `in_ready`, `stall` and the `iss_*` outputs with it. A second collision occurs when a new burst is accepted on the last beat of the one before. In that case the bench checks that the beat sequence restarts at offset 0 in the very next cycle.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_MRL   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_READ  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_REF   = 3'd6,
    CMD_OTHER = 3'd7
  } cmd_e;

  localparam logic [2:0] BL_FOUR = 3'b010;

  function automatic int unsigned gap_nonread(input int unsigned grade);
    return (grade == 0) ? 5 : 4;
  endfunction

  function automatic int unsigned gap_read(input int unsigned grade);
    return (grade == 0) ? 15 : 12;
  endfunction

endpackage

// File: rtl/mrg_mode_decode.sv
module mrg_mode_decode #(
  parameter int unsigned AW      = 13,
  parameter int unsigned DLL_BIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrl_fire,
  input  logic [AW-1:0] addr,
  output logic [2:0]    mode_bl,
  output logic          err_bl,
  output logic          err_bt,
  output logic          dll_pulse
);
  import mrg_pkg::*;

  logic bl_ok;
  assign bl_ok = (addr[2:0] == BL_FOUR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_bl   <= BL_FOUR;
      err_bl    <= 1'b0;
      err_bt    <= 1'b0;
      dll_pulse <= 1'b0;
    end else begin
      dll_pulse <= mrl_fire & addr[DLL_BIT];
      if (mrl_fire) begin
        err_bl <= ~bl_ok;
        err_bt <= addr[3];
        if (bl_ok) mode_bl <= addr[2:0];
      end
    end
  end

  // R2: a reserved code never replaces the stored burst length
  a_r2_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mrl_fire && addr[2:0] != BL_FOUR) |=> (err_bl && mode_bl == $past(mode_bl)));

  // R1: only the legal code is ever stored
  a_r1_legal_only: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bl == BL_FOUR);

  // R7: the DLL flag lasts one cycle unless a fresh MRL re-arms it
  a_r7_dll_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_pulse && !mrl_fire) |=> !dll_pulse);

endmodule

// File: rtl/mrg_gap_counter.sv
module mrg_gap_counter #(
  parameter int unsigned LOAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clr,
  output logic zero
);
  localparam int unsigned W = $clog2(LOAD + 2);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= LOAD_V;
    else if (clr)           cnt <= '0;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R4/R5: a running gap shrinks by exactly one per cycle
  a_r4_gap_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R5: a load always restarts the full gap
  a_r5_gap_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == LOAD_V));

endmodule

// File: rtl/mrg_col_burst.sv
module mrg_col_burst #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic [CW-3:0] base,
  output logic          col_valid,
  output logic          col_wr,
  output logic [CW-1:0] col_addr,
  output logic          col_last,
  output logic          can_start
);
  logic          active;
  logic [1:0]    beat;
  logic [CW-3:0] blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= 2'd0;
      blk    <= '0;
      col_wr <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= 2'd0;
      blk    <= base;
      col_wr <= start_wr;
    end else if (active) begin
      if (beat == 2'd3) active <= 1'b0;
      beat <= beat + 2'd1;
    end
  end

  assign col_valid = active;
  assign col_addr  = {blk, beat};
  assign col_last  = active && (beat == 2'd3);
  assign can_start = !active || (beat == 2'd3);

  // R10: offsets advance by one within the same block
  a_r10_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !start) |=>
      (col_valid && col_addr[1:0] == $past(col_addr[1:0]) + 2'd1 &&
       col_addr[CW-1:2] == $past(col_addr[CW-1:2])));

  // R10: a burst begins at offset zero
  a_r10_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_addr[1:0] == 2'd0));

  // R11: a new burst never cuts an unfinished one
  a_r11_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!col_valid || col_last));

endmodule

// File: rtl/mrs_timing_guard.sv
module mrs_timing_guard #(
  parameter int unsigned SPEED_GRADE = 0,
  parameter int unsigned AW          = 13,
  parameter int unsigned CW          = 10,
  parameter int unsigned DLL_BIT     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_cmd,
  input  logic [AW-1:0] in_addr,
  output logic          stall,
  output logic          iss_valid,
  output logic [2:0]    iss_cmd,
  output logic [AW-1:0] iss_addr,
  output logic [2:0]    mode_bl,
  output logic          err_bl,
  output logic          err_bt,
  output logic          dll_rst_pulse,
  output logic          col_valid,
  output logic          col_wr,
  output logic [CW-1:0] col_addr,
  output logic          col_last
);
  import mrg_pkg::*;

  localparam int unsigned TMRD  = gap_nonread(SPEED_GRADE);
  localparam int unsigned TMRDR = gap_read(SPEED_GRADE);
  localparam int unsigned SW    = $clog2(TMRDR + 2);

  logic is_nop, is_read, is_write, is_rw, is_mrl;
  logic nr_zero, rd_zero, burst_free;
  logic fire, mrl_fire, rw_fire, dll_req;

  assign is_nop   = (in_cmd == CMD_NOP);
  assign is_read  = (in_cmd == CMD_READ);
  assign is_write = (in_cmd == CMD_WRITE);
  assign is_mrl   = (in_cmd == CMD_MRL);
  assign is_rw    = is_read | is_write;

  always_comb begin
    if (is_nop)       in_ready = 1'b1;
    else if (is_read) in_ready = rd_zero & burst_free;
    else if (is_write) in_ready = nr_zero & burst_free;
    else              in_ready = nr_zero;
  end

  assign fire      = in_valid & in_ready;
  assign stall     = in_valid & ~in_ready;
  assign mrl_fire  = fire & is_mrl;
  assign rw_fire   = fire & is_rw;
  assign dll_req   = in_addr[DLL_BIT];

  assign iss_valid = fire;
  assign iss_cmd   = in_cmd;
  assign iss_addr  = is_rw ? {in_addr[AW-1:2], 2'b00} : in_addr;

  mrg_mode_decode #(.AW(AW), .DLL_BIT(DLL_BIT)) u_decode (
    .clk(clk), .rst_n(rst_n), .mrl_fire(mrl_fire), .addr(in_addr),
    .mode_bl(mode_bl), .err_bl(err_bl), .err_bt(err_bt), .dll_pulse(dll_rst_pulse)
  );

  mrg_gap_counter #(.LOAD(TMRD - 1)) u_gap_nr (
    .clk(clk), .rst_n(rst_n), .load(mrl_fire & ~dll_req),
    .clr(mrl_fire & dll_req), .zero(nr_zero)
  );

  mrg_gap_counter #(.LOAD(TMRDR - 1)) u_gap_rd (
    .clk(clk), .rst_n(rst_n), .load(mrl_fire), .clr(1'b0), .zero(rd_zero)
  );

  mrg_col_burst #(.CW(CW)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(rw_fire), .start_wr(is_write),
    .base(in_addr[CW-1:2]), .col_valid(col_valid), .col_wr(col_wr),
    .col_addr(col_addr), .col_last(col_last), .can_start(burst_free)
  );

  // Independent age of the last MRL, saturating, for the timing checks
  logic [SW-1:0] age;
  logic          seen, seen_dll;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0; seen <= 1'b0; seen_dll <= 1'b0;
    end else if (mrl_fire) begin
      age <= SW'(1); seen <= 1'b1; seen_dll <= dll_req;
    end else if (age < SW'(TMRDR)) begin
      age <= age + 1'b1;
    end
  end

  // R5: READ never leaves before the read gap
  a_r5_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == CMD_READ && seen) |-> (age >= SW'(TMRDR)));

  // R4: non-read never leaves before the short gap, unless DLL reset
  a_r4_nonread_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd != CMD_READ && iss_cmd != CMD_NOP && seen && !seen_dll)
      |-> (age >= SW'(TMRD)));

  // R6: NOP is never held back
  a_r6_nop_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cmd == CMD_NOP) |-> (iss_valid && !stall));

  // R9: issued column accesses are block aligned
  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_cmd == CMD_READ || iss_cmd == CMD_WRITE)) |-> (iss_addr[1:0] == 2'b00));

endmodule

// File: tb/mrs_timing_guard_bench.sv
module mrs_timing_guard_bench;
  localparam int AW = 13;
  localparam int CW = 10;
  localparam int GRADE = 0;
  localparam int T_NR = (GRADE == 0) ? 5 : 4;
  localparam int T_RD = (GRADE == 0) ? 15 : 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_cmd = 3'd0;
  logic [AW-1:0] in_addr = '0;
  logic in_ready, stall, iss_valid, err_bl, err_bt, dll_rst_pulse;
  logic col_valid, col_wr, col_last;
  logic [2:0] iss_cmd, mode_bl;
  logic [AW-1:0] iss_addr;
  logic [CW-1:0] col_addr;

  always #5 clk = ~clk;

  mrs_timing_guard #(.SPEED_GRADE(GRADE), .AW(AW), .CW(CW), .DLL_BIT(8)) u_mrs_timing_guard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_addr(in_addr), .stall(stall), .iss_valid(iss_valid),
    .iss_cmd(iss_cmd), .iss_addr(iss_addr), .mode_bl(mode_bl), .err_bl(err_bl),
    .err_bt(err_bt), .dll_rst_pulse(dll_rst_pulse), .col_valid(col_valid),
    .col_wr(col_wr), .col_addr(col_addr), .col_last(col_last)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model state
  int m_nr = 0, m_rd = 0, m_beat = 0;
  logic [2:0] m_bl = 3'b010;
  bit m_ebl = 0, m_ebt = 0, m_dll = 0, m_wr = 0;
  logic [CW-3:0] m_base = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ready(input logic [2:0] c);
    bit bfree = (m_beat == 0) || (m_beat == 4);
    if (c == 3'd0) return 1;
    if (c == 3'd3) return (m_rd == 0) && bfree;
    if (c == 3'd4) return (m_nr == 0) && bfree;
    return (m_nr == 0);
  endfunction

  function automatic string ready_req(input logic [2:0] c);
    bit bfree = (m_beat == 0) || (m_beat == 4);
    if (c == 3'd0) return "R6";
    if ((c == 3'd3 || c == 3'd4) && !bfree) return "R11";
    if (c == 3'd3) return "R5";
    return "R4";
  endfunction

  task automatic check_regs();
    check(mode_bl == m_bl, "R1", "mode_bl", mode_bl, m_bl);
    check(err_bl == m_ebl, "R2", "err_bl", err_bl, m_ebl);
    check(err_bt == m_ebt, "R3", "err_bt", err_bt, m_ebt);
    check(dll_rst_pulse == m_dll, "R7", "dll_rst_pulse", dll_rst_pulse, m_dll);
    check(col_valid == (m_beat != 0), "R10", "col_valid", col_valid, m_beat != 0);
    if (m_beat != 0) begin
      check(col_addr == {m_base, 2'(m_beat - 1)}, "R10", "col_addr", col_addr, {m_base, 2'(m_beat - 1)});
      check(col_last == (m_beat == 4), "R10", "col_last", col_last, m_beat == 4);
      check(col_wr == m_wr, "R10", "col_wr", col_wr, m_wr);
    end
  endtask

  // one cycle: returns whether the command was taken
  task automatic cycle(input bit v, input logic [2:0] c, input logic [AW-1:0] a, output bit taken);
    bit er;
    @(negedge clk);
    check_regs();
    in_valid = v; in_cmd = c; in_addr = a;
    #1;
    er = exp_ready(c);
    check(in_ready == er, ready_req(c), "in_ready", in_ready, er);
    check(stall == (v && !er), "R12", "stall", stall, v && !er);
    check(iss_valid == (v && er), "R8", "iss_valid", iss_valid, v && er);
    taken = v && er;
    if (taken) begin
      check(iss_cmd == c, "R8", "iss_cmd", iss_cmd, c);
      if (c == 3'd3 || c == 3'd4)
        check(iss_addr == {a[AW-1:2], 2'b00}, "R9", "iss_addr", iss_addr, {a[AW-1:2], 2'b00});
      else
        check(iss_addr == a, "R9", "iss_addr", iss_addr, a);
    end
    // advance model to the post-edge state
    if (m_beat != 0) m_beat = (m_beat == 4) ? 0 : m_beat + 1;
    m_dll = 0;
    if (taken && c == 3'd1) begin
      m_ebl = (a[2:0] != 3'b010);
      if (!m_ebl) m_bl = a[2:0];
      m_ebt = a[3];
      m_dll = a[8];
      m_nr = a[8] ? 0 : T_NR - 1;
      m_rd = T_RD - 1;
    end else begin
      if (m_nr > 0) m_nr--;
      if (m_rd > 0) m_rd--;
    end
    if (taken && (c == 3'd3 || c == 3'd4)) begin
      m_beat = 1; m_base = a[CW-1:2]; m_wr = (c == 3'd4);
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [AW-1:0] a);
    bit t = 0;
    int n = 0;
    while (!t && n < 100) begin
      cycle(1'b1, c, a, t);
      n++;
    end
    check(t, "R8", "command taken", t, 1);
  endtask

  task automatic send_nop();
    bit t;
    cycle(1'b1, 3'd0, AW'($urandom), t);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit t;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // reset state: R1 R2 R3 R7 R10
    check_regs();
    rst_n = 1'b1;
    // directed: READ held for the full read gap (R5)
    send(3'd1, 13'h002);
    send(3'd3, 13'h0137);
    // write after it, with burst collision (R11, R4)
    send(3'd4, 13'h02A1);
    // MRL inside a burst, then READ/WRITE chase both limits
    send(3'd3, 13'h0044);
    send(3'd1, 13'h002);
    send(3'd4, 13'h0010);
    send(3'd3, 13'h0020);
    send(3'd3, 13'h03FF);
    // DLL reset MRL: non-read passes at once, read waits (R7)
    send(3'd1, 13'h102);
    send(3'd2, 13'h0555);
    send(3'd3, 13'h0008);
    // reserved burst length and interleave request (R2, R3)
    send(3'd1, 13'h005);
    send_nop();
    send(3'd1, 13'h00A);
    send_nop();
    send(3'd1, 13'h002);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [AW-1:0] a = AW'($urandom);
      if (r < 25) begin
        cycle(1'b0, 3'($urandom), a, t);
      end else if (r < 45) begin
        send_nop();
      end else if (r < 53) begin
        if ($urandom_range(0, 9) < 7) a[2:0] = 3'b010;
        a[3] = ($urandom_range(0, 4) == 0);
        a[8] = ($urandom_range(0, 4) == 0);
        send(3'd1, a);
      end else if (r < 72) begin
        send(3'd3, a);
      end else if (r < 88) begin
        send(3'd4, a);
      end else begin
        send(3'($urandom_range(5, 7)), a);
      end
    end
    repeat (20) cycle(1'b0, 3'd0, '0, t);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule